// File: doc/BRIEF.md
# Hardware Sprite Pixel Generator

The block overlays up to sixteen small bitmap objects on a raster display. Each object owns a 16 x 16 image of 4-bit pixels, a signed horizontal and vertical origin, and a pair of zoom codes. A byte-wide processor bus writes all of this state and can read back the images and the origins. On every clock the block receives the beam coordinate being drawn and, two clocks later, reports whether an object covers that point and which palette entry it selects. A downstream mixer uses the flag to replace the background colour.

The processor sees a 16 KiB page. Images occupy the bottom 4 KiB, one 256-byte block per object, with the pixel at row r and column c held at byte r*16+c of its block. The per-object control groups sit from offset 0x2000 at an 8-byte stride. Each object is evaluated in parallel, and a fixed priority among them resolves overlaps.

Top module: `sprite_pixel_gen`

## Requirements
- R1: After reset every object is hidden: `spr_valid` and `spr_index` are 0 until a zoom byte enabling both axes is written, regardless of image or origin contents.
- R2: A write to image offset s*256+r*16+c stores bits 3..0 of the data as pixel (r,c) of object s. A read returns that nibble in bits 3..0 with bits 7..4 zero, on `cpu_rdata` in the cycle after `cpu_rd` is sampled.
- R3: Within the group at 0x2000+8*s, bytes 0/1 are the low/high bytes of the X origin and bytes 2/3 the low/high bytes of the Y origin. All four read back, one cycle after `cpu_rd`, the value last written.
- R4: Byte 4 of a group holds the zoom code, X in bits 3..2 and Y in bits 1..0. It is write-only and reads as 0. Bytes 5..7 read as 0 and writes to them change nothing.
- R5: Writes outside the image area (offset 0x1000 and above) and outside the control groups (0x2080 and above) change no object state.
- R6: `spr_valid`/`spr_index` reflect the beam coordinate sampled two rising edges earlier. With beam and bus quiet, they hold steady.
- R7: An object whose X or Y zoom field is 00 produces no pixel.
- R8: Zoom codes 01, 10, 11 scale by 1, 2, 4. Pixel column = (beam_x - X) >> (code-1), row = (beam_y - Y) >> (code-1). The object covers only points where both lie in 0..15.
- R9: Origins and beam coordinates are 16-bit two's-complement, so an object may start left of or above coordinate 0.
- R10: Pixel value 0 is transparent. Among objects with a non-zero pixel at a point, the lowest-numbered one supplies `spr_index`. `spr_valid` high always comes with a non-zero index.
- R11: A write to an image byte or origin byte is seen by a beam coordinate presented in the cycle after the write edge. A coordinate presented in the write cycle itself still sees the old value.
- R12: When `spr_valid` is 0, `spr_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 14 | Byte offset within the register page |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| beam_x | input | 16 | Signed horizontal beam coordinate |
| beam_y | input | 16 | Signed vertical beam coordinate |
| spr_valid | output | 1 | An object pixel covers the coordinate |
| spr_index | output | 4 | Palette index of the winning pixel |

## Verification
Most internal faults surface on the pixel outputs within two clocks of the beam coordinate that touches them. A wrong zoom shift or origin subtraction moves or resizes the image. A wrong priority order swaps which object shows where two overlap. A decode slip in the write path corrupts an object's image or origin, so its read-back bytes and its drawn pixels both diverge from the bench model at the next probe. Faults confined to the read mux show up only on the next read of the affected byte.

// File: rtl/sprite_pkg.sv
package sprite_pkg;
  localparam int COORD_W = 16;

  typedef struct packed {
    logic [COORD_W-1:0] xpos;
    logic [COORD_W-1:0] ypos;
    logic [1:0]         zoom_x;
    logic [1:0]         zoom_y;
  } spr_cfg_t;

  // zoom code 01/10/11 -> shift 0/1/2 (code 00 never reaches the shifter)
  function automatic logic [1:0] zoom_shift(input logic [1:0] code);
    return code - 2'd1;
  endfunction
endpackage

// File: rtl/sprite_cfg_regs.sv
module sprite_cfg_regs
  import sprite_pkg::*;
#(
  parameter int NSPR     = 16,
  parameter int AW       = 14,
  parameter int POS_BASE = 32'h2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  output spr_cfg_t [NSPR-1:0]  cfg,
  output logic [7:0]           rd_byte
);
  localparam int SEL_W = $clog2(NSPR);
  localparam int SPAN  = NSPR * 8;

  logic [COORD_W-1:0] xpos_r [NSPR];
  logic [COORD_W-1:0] ypos_r [NSPR];
  logic [1:0]         zx_r   [NSPR];
  logic [1:0]         zy_r   [NSPR];

  logic            in_grp;
  logic [AW-1:0]   off;
  logic [SEL_W-1:0] sel;
  logic [2:0]      fld;

  assign in_grp = (int'(addr) >= POS_BASE) && (int'(addr) < POS_BASE + SPAN);
  assign off    = addr - AW'(POS_BASE);
  assign sel    = off[3 +: SEL_W];
  assign fld    = off[2:0];

  // origins have no reset; their power-up value is undefined
  always_ff @(posedge clk) begin
    if (wr_en && in_grp) begin
      case (fld)
        3'd0: xpos_r[sel][7:0]  <= wdata;
        3'd1: xpos_r[sel][15:8] <= wdata;
        3'd2: ypos_r[sel][7:0]  <= wdata;
        3'd3: ypos_r[sel][15:8] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSPR; i++) begin
        zx_r[i] <= '0;
        zy_r[i] <= '0;
      end
    end else if (wr_en && in_grp && fld == 3'd4) begin
      zx_r[sel] <= wdata[3:2];
      zy_r[sel] <= wdata[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_byte <= '0;
    end else if (rd_en && in_grp) begin
      case (fld)
        3'd0:    rd_byte <= xpos_r[sel][7:0];
        3'd1:    rd_byte <= xpos_r[sel][15:8];
        3'd2:    rd_byte <= ypos_r[sel][7:0];
        3'd3:    rd_byte <= ypos_r[sel][15:8];
        default: rd_byte <= '0;
      endcase
    end else begin
      rd_byte <= '0;
    end
  end

  for (genvar g = 0; g < NSPR; g++) begin : g_cfg
    assign cfg[g] = '{xpos: xpos_r[g], ypos: ypos_r[g], zoom_x: zx_r[g], zoom_y: zy_r[g]};
  end
endmodule

// File: rtl/sprite_img_ram.sv
module sprite_img_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic [ADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_q
);
  logic [DATA_W-1:0] mem [2**ADDR_W];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_q <= mem[b_addr];
  end
endmodule

// File: rtl/sprite_locate.sv
module sprite_locate
  import sprite_pkg::*;
#(
  parameter int IMG_LG = 4
) (
  input  logic [COORD_W-1:0]  beam_x,
  input  logic [COORD_W-1:0]  beam_y,
  input  spr_cfg_t            cfg,
  output logic                hit,
  output logic [2*IMG_LG-1:0] pix_addr
);
  localparam int IMG_N = 1 << IMG_LG;

  logic signed [COORD_W:0] dx, dy;
  logic        [COORD_W:0] col, row;
  logic                    in_x, in_y;

  assign dx  = $signed({beam_x[COORD_W-1], beam_x}) - $signed({cfg.xpos[COORD_W-1], cfg.xpos});
  assign dy  = $signed({beam_y[COORD_W-1], beam_y}) - $signed({cfg.ypos[COORD_W-1], cfg.ypos});
  assign col = dx >> zoom_shift(cfg.zoom_x);
  assign row = dy >> zoom_shift(cfg.zoom_y);

  assign in_x = !dx[COORD_W] && (col < (COORD_W+1)'(IMG_N));
  assign in_y = !dy[COORD_W] && (row < (COORD_W+1)'(IMG_N));
  assign hit  = (cfg.zoom_x != 2'd0) && (cfg.zoom_y != 2'd0) && in_x && in_y;
  assign pix_addr = {row[IMG_LG-1:0], col[IMG_LG-1:0]};
endmodule

// File: rtl/sprite_pixel_gen.sv
module sprite_pixel_gen
  import sprite_pkg::*;
#(
  parameter int NSPR     = 16,
  parameter int IMG_LG   = 4,
  parameter int PIX_W    = 4,
  parameter int AW       = 14,
  parameter int POS_BASE = 32'h2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      cpu_addr,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  input  logic [7:0]         cpu_wdata,
  output logic [7:0]         cpu_rdata,
  input  logic [COORD_W-1:0] beam_x,
  input  logic [COORD_W-1:0] beam_y,
  output logic               spr_valid,
  output logic [PIX_W-1:0]   spr_index
);
  localparam int PIX_AW   = 2 * IMG_LG;
  localparam int SEL_W    = $clog2(NSPR);
  localparam int IMG_SPAN = NSPR << PIX_AW;

  spr_cfg_t [NSPR-1:0] cfg;
  logic [7:0]          pos_rd;
  logic                in_img;
  logic [SEL_W-1:0]    img_sel;

  logic [NSPR-1:0]     hit, hit_q;
  logic [PIX_AW-1:0]   loc_addr [NSPR];
  logic [PIX_W-1:0]    pix_q    [NSPR];
  logic [PIX_W-1:0]    img_q    [NSPR];

  logic                rd_img_q;
  logic [SEL_W-1:0]    rd_sel_q;
  logic                win_valid;
  logic [PIX_W-1:0]    win_idx;

  assign in_img  = int'(cpu_addr) < IMG_SPAN;
  assign img_sel = cpu_addr[PIX_AW +: SEL_W];

  sprite_cfg_regs #(.NSPR(NSPR), .AW(AW), .POS_BASE(POS_BASE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(cpu_wr), .rd_en(cpu_rd), .addr(cpu_addr),
    .wdata(cpu_wdata), .cfg(cfg), .rd_byte(pos_rd)
  );

  for (genvar s = 0; s < NSPR; s++) begin : g_spr
    sprite_locate #(.IMG_LG(IMG_LG)) u_loc (
      .beam_x(beam_x), .beam_y(beam_y), .cfg(cfg[s]),
      .hit(hit[s]), .pix_addr(loc_addr[s])
    );
    sprite_img_ram #(.ADDR_W(PIX_AW), .DATA_W(PIX_W)) u_ram (
      .clk(clk),
      .a_we(cpu_wr && in_img && img_sel == SEL_W'(s)),
      .a_addr(cpu_addr[PIX_AW-1:0]), .a_wdata(cpu_wdata[PIX_W-1:0]), .a_q(img_q[s]),
      .b_addr(loc_addr[s]), .b_q(pix_q[s])
    );
  end

  // stage 1: coverage flags line up with the registered pixel reads
  always_ff @(posedge clk) begin
    if (rst) hit_q <= '0;
    else     hit_q <= hit;
  end

  // stage 2: fixed priority, lowest object number wins
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int s = NSPR - 1; s >= 0; s--) begin
      if (hit_q[s] && pix_q[s] != '0) begin
        win_valid = 1'b1;
        win_idx   = pix_q[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_valid <= 1'b0;
      spr_index <= '0;
    end else begin
      spr_valid <= win_valid;
      spr_index <= win_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_img_q <= 1'b0;
      rd_sel_q <= '0;
    end else begin
      rd_img_q <= cpu_rd && in_img;
      rd_sel_q <= img_sel;
    end
  end

  assign cpu_rdata = rd_img_q ? {{(8-PIX_W){1'b0}}, img_q[rd_sel_q]} : pos_rd;
endmodule

// File: rtl/sprite_pixel_gen_chk.sv
module sprite_pixel_gen_chk #(
  parameter int NSPR     = 16,
  parameter int IMG_LG   = 4,
  parameter int PIX_W    = 4,
  parameter int AW       = 14,
  parameter int POS_BASE = 32'h2000
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    cpu_addr,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic [7:0]       cpu_wdata,
  input logic [7:0]       cpu_rdata,
  input logic [15:0]      beam_x,
  input logic [15:0]      beam_y,
  input logic             spr_valid,
  input logic [PIX_W-1:0] spr_index
);
  logic zoom_addr, img_addr;
  logic shown, shown_d1, shown_d2;
  logic [15:0] bx_q, by_q;
  logic wr_q;
  logic [2:0] quiet_cnt;

  assign zoom_addr = (int'(cpu_addr) >= POS_BASE) && (int'(cpu_addr) < POS_BASE + NSPR * 8)
                     && (cpu_addr[2:0] == 3'd4);
  assign img_addr  = int'(cpu_addr) < (NSPR << (2 * IMG_LG));

  always_ff @(posedge clk) begin
    if (rst) begin
      shown    <= 1'b0;
      shown_d1 <= 1'b0;
      shown_d2 <= 1'b0;
    end else begin
      if (cpu_wr && zoom_addr && cpu_wdata[3:2] != 2'd0 && cpu_wdata[1:0] != 2'd0) shown <= 1'b1;
      shown_d1 <= shown;
      shown_d2 <= shown_d1;
    end
  end

  always_ff @(posedge clk) begin
    bx_q <= beam_x;
    by_q <= beam_y;
    wr_q <= cpu_wr;
    if (rst) quiet_cnt <= '0;
    else if (beam_x == bx_q && beam_y == by_q && !cpu_wr && !wr_q)
      quiet_cnt <= (quiet_cnt == 3'd4) ? 3'd4 : quiet_cnt + 3'd1;
    else quiet_cnt <= '0;
  end

  AST_IDLE_INDEX_ZERO: assert property (@(posedge clk) disable iff (rst)
    !spr_valid |-> spr_index == '0); // R12
  AST_SHOWN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    spr_valid |-> spr_index != '0); // R10
  AST_HIDDEN_UNTIL_ZOOM: assert property (@(posedge clk) disable iff (rst)
    !shown_d2 |-> !spr_valid); // R1
  AST_ZOOM_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && zoom_addr) |=> cpu_rdata == 8'd0); // R4
  AST_IMG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && img_addr) |=> cpu_rdata[7:4] == 4'd0); // R2
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (rst)
    (quiet_cnt == 3'd4) |-> $stable({spr_valid, spr_index})); // R6
endmodule

bind sprite_pixel_gen sprite_pixel_gen_chk #(
  .NSPR(NSPR), .IMG_LG(IMG_LG), .PIX_W(PIX_W), .AW(AW), .POS_BASE(POS_BASE)
) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .beam_x(beam_x), .beam_y(beam_y),
  .spr_valid(spr_valid), .spr_index(spr_index)
);

// File: tb/sim_sprite_pixel_gen.sv
`timescale 1ns/1ps
module sim_sprite_pixel_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [15:0] beam_x = '0, beam_y = '0;
  logic        spr_valid;
  logic [3:0]  spr_index;

  int errors = 0;
  int checks = 0;

  logic [3:0]  m_img [16][256];
  logic [15:0] m_x [16];
  logic [15:0] m_y [16];
  logic [3:0]  m_zoom [16];

  always #2 clk = ~clk;

  sprite_pixel_gen u0 (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .beam_x(beam_x), .beam_y(beam_y),
    .spr_valid(spr_valid), .spr_index(spr_index)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // expected {valid, index} from the requirements (R7..R10)
  function automatic logic [4:0] ref_pix(input int bx, input int by);
    for (int s = 0; s < 16; s++) begin
      int zx, zy, dx, dy, c, r;
      zx = m_zoom[s][3:2];
      zy = m_zoom[s][1:0];
      if (zx == 0 || zy == 0) continue;
      dx = bx - int'($signed(m_x[s]));
      dy = by - int'($signed(m_y[s]));
      if (dx < 0 || dy < 0) continue;
      c = dx >> (zx - 1);
      r = dy >> (zy - 1);
      if (c > 15 || r > 15) continue;
      if (m_img[s][r*16+c] != 4'd0) return {1'b1, m_img[s][r*16+c]};
    end
    return 5'd0;
  endfunction

  function automatic void model_write(input int a, input logic [7:0] d);
    if (a < 32'h1000) m_img[a >> 8][a & 255] = d[3:0];
    else if (a >= 32'h2000 && a < 32'h2080) begin
      int s;
      s = (a - 32'h2000) >> 3;
      case (a & 7)
        0: m_x[s][7:0]  = d;
        1: m_x[s][15:8] = d;
        2: m_y[s][7:0]  = d;
        3: m_y[s][15:8] = d;
        4: m_zoom[s]    = d[3:0];
        default: ;
      endcase
    end
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = 14'(a); cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = 14'(a); cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    d = cpu_rdata;
  endtask

  task automatic set_pos(input int s, input int x, input int y);
    wr(32'h2000 + 8*s + 0, 8'(x));
    wr(32'h2000 + 8*s + 1, 8'(x >> 8));
    wr(32'h2000 + 8*s + 2, 8'(y));
    wr(32'h2000 + 8*s + 3, 8'(y >> 8));
  endtask

  task automatic probe(input int bx, input int by, input string req);
    logic [4:0] e;
    @(negedge clk);
    beam_x = 16'(bx); beam_y = 16'(by);
    e = ref_pix(bx, by);
    @(negedge clk);
    @(negedge clk);
    chk({spr_valid, spr_index} == e, req, "pixel", {spr_valid, spr_index}, e);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [4:0] ring [3];
    void'($urandom(32'd20240705));
    for (int s = 0; s < 16; s++) begin
      m_x[s] = '0; m_y[s] = '0; m_zoom[s] = '0;
      for (int b = 0; b < 256; b++) m_img[s][b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(spr_valid == 1'b0 && spr_index == 4'd0, "R1", "reset outputs", {spr_valid, spr_index}, 0);

    for (int s = 0; s < 16; s++) begin
      set_pos(s, 0, 0);
      for (int b = 0; b < 256; b++) wr(s*256 + b, 8'h00);
    end
    wr(32'h0000, 8'h0F);
    probe(0, 0, "R1");

    // R2: nibble storage and readback
    wr(32'h0312, 8'hAB);
    rd(32'h0312, d);
    chk(d == 8'h0B, "R2", "image readback", d, 8'h0B);
    // R3: origin bytes
    set_pos(5, 32'h1234, 32'hFEDC);
    rd(32'h2028, d); chk(d == 8'h34, "R3", "x low", d, 8'h34);
    rd(32'h2029, d); chk(d == 8'h12, "R3", "x high", d, 8'h12);
    rd(32'h202B, d); chk(d == 8'hFE, "R3", "y high", d, 8'hFE);
    // R4: zoom write-only, spare bytes inert
    wr(32'h202C, 8'h0F);
    rd(32'h202C, d); chk(d == 8'h00, "R4", "zoom reads zero", d, 0);
    wr(32'h2005, 8'hFF);
    rd(32'h2005, d); chk(d == 8'h00, "R4", "spare byte", d, 0);
    wr(32'h202C, 8'h00);

    // R8: sprite 0 at (10,20), X x2, Y x4
    set_pos(0, 10, 20);
    wr(32'h0000, 8'h00);
    wr(32'h0013, 8'h07);
    wr(32'h001F, 8'h09);
    wr(32'h2004, 8'h0B);
    probe(17, 27, "R8");
    probe(41, 27, "R8");
    probe(42, 27, "R8");
    probe(10, 84, "R8");

    // R5: writes beyond the decoded regions
    wr(32'h1000, 8'hFF);
    wr(32'h2080, 8'h00);
    wr(32'h3FFF, 8'hFF);
    rd(32'h0000, d); chk(d == 8'h00, "R5", "image byte untouched", d, 0);
    rd(32'h2000, d); chk(d == 8'd10, "R5", "origin untouched", d, 10);
    probe(10, 20, "R5");

    // R9: negative origin
    set_pos(1, -5, 0);
    wr(32'h0105, 8'h03);
    wr(32'h010F, 8'h06);
    wr(32'h200C, 8'h05);
    probe(0, 0, "R9");
    probe(10, 0, "R9");
    probe(11, 0, "R9");
    probe(-5, 0, "R9");

    // R10: overlap priority and transparency
    set_pos(2, 100, 100);
    set_pos(3, 100, 100);
    wr(32'h0200, 8'h04); wr(32'h0300, 8'h05);
    wr(32'h0301, 8'h08);
    wr(32'h2014, 8'h05); wr(32'h201C, 8'h05);
    probe(100, 100, "R10");
    probe(101, 100, "R10");

    // R7: one axis hidden
    set_pos(4, 200, 200);
    wr(32'h0400, 8'h02);
    wr(32'h2024, 8'h01); probe(200, 200, "R7");
    wr(32'h2024, 8'h04); probe(200, 200, "R7");
    wr(32'h2024, 8'h05); probe(200, 200, "R7");

    // R11: write and probe in adjacent cycles
    @(negedge clk);
    cpu_addr = 14'h0400; cpu_wdata = 8'h0C; cpu_wr = 1'b1;
    beam_x = 16'd200; beam_y = 16'd200;
    @(negedge clk);
    cpu_wr = 1'b0;
    @(negedge clk);
    chk(spr_valid && spr_index == 4'h2, "R11", "write-cycle sees old", spr_index, 2);
    @(negedge clk);
    chk(spr_valid && spr_index == 4'hC, "R11", "next cycle sees new", spr_index, 12);
    model_write(32'h0400, 8'h0C);

    // random configuration and beam stream (R6, R8, R10, R12)
    for (int s = 0; s < 16; s++) begin
      set_pos(s, int'($urandom_range(0, 110)) - 20, int'($urandom_range(0, 110)) - 20);
      wr(32'h2000 + 8*s + 4, 8'($urandom));
      for (int b = 0; b < 256; b++) begin
        logic [7:0] v;
        v = 8'($urandom);
        if ($urandom_range(0, 2) == 0) v[3:0] = 4'd0;
        wr(s*256 + b, v);
      end
    end
    for (int i = 0; i < 3002; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk({spr_valid, spr_index} == ring[(i-2)%3], "R6", "stream pixel",
            {spr_valid, spr_index}, ring[(i-2)%3]);
        chk(spr_valid || spr_index == 4'd0, "R12", "idle index", spr_index, 0);
      end
      if (i < 3000) begin
        int bx, by;
        bx = int'($urandom_range(0, 160)) - 20;
        by = int'($urandom_range(0, 160)) - 20;
        beam_x = 16'(bx); beam_y = 16'(by);
        ring[i%3] = ref_pix(bx, by);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule